// File: doc/BRIEF.md
# Supply Event Status and Power-Down Timestamp

This block keeps the supply-health flags of a timekeeping chip and records when main power was lost. Digital comparator outputs come in asynchronously. The inputs report supply below trip, supply back above trip plus hysteresis, battery under 85 %, battery under 75 % and switchover to battery. Each input is resynchronised before it is used. Rising edges of the supply inputs set sticky flags. A read of the status register clears those flags. The battery inputs are reported as live levels.

On the first switchover to battery, the block copies the live calendar time from the counter bus into six timestamp registers. Later switchovers leave that value alone. Software clears each timestamp register on its own by writing zero to it. A new capture is armed only when all six registers are zero again. A small register port gives access to the status byte, a 3-bit field that selects the supply trip level, and the timestamp.

Top module: `supply_event_log`

## Requirements
- R1: After reset, the following are all zero: status_o, stamp_o, trip_sel_o and reg_rdata_o. brownout_n_o is high.
- R2: A rising edge on cmp_vlow_i sets the brown-out flag (status bit 0) after the third clock edge. brownout_n_o is low whenever that flag is set.
- R3: A read of address 0 returns the status byte on reg_rdata_o after the next edge. The byte is {4'b0, bat75, bat85, restored, brownout}. The same read clears the brown-out and supply-restored flags.
- R4: A rising edge on cmp_vok_i sets the supply-restored flag (status bit 1) after the third clock edge.
- R5: Status bit 2 is high while either battery comparator is high. Status bit 3 follows cmp_b75_i. Both bits follow the inputs after two clock edges, and a read does not clear them.
- R6: If all timestamp bytes are zero, a rising edge on cmp_swo_i copies now_i into the timestamp after the third clock edge. Byte i sits at bits [8i+7:8i] and is read at address 2+i, in the order seconds, minutes, hours, date, month, year.
- R7: While any timestamp byte is non-zero, further switchover edges leave the timestamp unchanged.
- R8: Writing 00h to address 2+i clears timestamp byte i only. A non-zero write to a timestamp address is ignored. A capture is armed again only when all six bytes are zero.
- R9: Address 1 holds the trip-level field in bits [2:0], which is readable and writable. Its upper bits read as zero.
- R10: If a status read and a new brown-out edge fall in the same cycle, the flag ends up set.
- R11: A comparator held high sets its flag only once. After a clearing read, the flag stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_vlow_i | input | 1 | Supply below trip level |
| cmp_vok_i | input | 1 | Supply above trip plus hysteresis |
| cmp_b85_i | input | 1 | Battery below 85 % |
| cmp_b75_i | input | 1 | Battery below 75 % |
| cmp_swo_i | input | 1 | Switched over to battery |
| now_i | input | 48 | Live calendar time, six bytes |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| status_o | output | 4 | {bat75, bat85, restored, brownout} |
| brownout_n_o | output | 1 | Active-low brown-out reset |
| trip_sel_o | output | 3 | Trip-level selection field |
| stamp_o | output | 48 | Timestamp registers |

## Verification
Each comparator input passes through two synchroniser flops and one edge flop. A sticky flag or a timestamp capture therefore appears after the third rising edge following the input change. The battery status bits appear after the second. Read data and register writes take effect after one edge. The bench drives every input on the falling edge and counts falling edges to the exact cycle each result is due. Read expectations are queued when the strobe is issued and popped by a monitor one cycle later. The set-versus-clear race is forced by issuing the read two falling edges after raising the comparator, so the read lands in the cycle of the synchronised edge.

// File: rtl/sel_pkg.sv
package sel_pkg;
  // Fixed register addresses; the timestamp bytes start at STAMP_BASE
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_TRIP   = 1;
  localparam int STAMP_BASE  = 2;

  // Battery warning code {below75, below85}: below 75 implies below 85
  function automatic logic [1:0] bat_code(input logic lo85, input logic lo75);
    return {lo75, lo85 | lo75};
  endfunction

  // Status nibble {bat75, bat85, restored, brownout}
  function automatic logic [3:0] pack_status(input logic bo, input logic pr,
                                             input logic [1:0] bat);
    return {bat[1], bat[0], pr, bo};
  endfunction
endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
  parameter int N    = 1,
  parameter bit EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] out_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= raw_i[i];
        s2 <= s1;
      end
    end
    if (EDGE) begin : g_edge
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= s2;
      end
      assign out_o[i] = s2 & ~prev;
    end else begin : g_level
      assign out_o[i] = s2;
    end
  end
endmodule

// File: rtl/sel_status.sv
module sel_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vlow_rise_i,
  input  logic       vok_rise_i,
  input  logic       lo85_i,
  input  logic       lo75_i,
  input  logic       rd_clear_i,
  output logic       bo_o,
  output logic       pr_o,
  output logic [1:0] bat_o
);
  // Set has priority over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_o <= 1'b0;
      pr_o <= 1'b0;
    end else begin
      if (vlow_rise_i)     bo_o <= 1'b1;
      else if (rd_clear_i) bo_o <= 1'b0;
      if (vok_rise_i)      pr_o <= 1'b1;
      else if (rd_clear_i) pr_o <= 1'b0;
    end
  end

  assign bat_o = sel_pkg::bat_code(lo85_i, lo75_i);
endmodule

// File: rtl/sel_stamp.sv
module sel_stamp #(
  parameter int NF = 6,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_i,
  input  logic [NF*W-1:0] now_i,
  input  logic [NF-1:0] wr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [NF*W-1:0] stamp_o,
  output logic          empty_o
);
  logic take;
  logic zero_wr;

  assign empty_o = (stamp_o == '0);
  assign take    = capture_i & empty_o;
  assign zero_wr = (wdata_i == '0);

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 stamp_o[i*W +: W] <= '0;
      else if (take)              stamp_o[i*W +: W] <= now_i[i*W +: W];
      else if (wr_i[i] && zero_wr) stamp_o[i*W +: W] <= '0;
    end
  end
endmodule

// File: rtl/supply_event_log.sv
module supply_event_log #(
  parameter int NF     = 6,
  parameter int W      = 8,
  parameter int ADDR_W = 3,
  parameter int TRIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_vlow_i,
  input  logic              cmp_vok_i,
  input  logic              cmp_b85_i,
  input  logic              cmp_b75_i,
  input  logic              cmp_swo_i,
  input  logic [NF*W-1:0]   now_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [W-1:0]      reg_wdata_i,
  output logic [W-1:0]      reg_rdata_o,
  output logic [3:0]        status_o,
  output logic              brownout_n_o,
  output logic [TRIP_W-1:0] trip_sel_o,
  output logic [NF*W-1:0]   stamp_o
);
  import sel_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_TRIP   = ADDR_W'(ADDR_TRIP);

  // Named internal events, observed by the bound checker
  logic [2:0]    edges;
  logic [1:0]    levels;
  logic          ev_vlow_rise, ev_vok_rise, ev_swo_rise;
  logic          rd_status;
  logic          stamp_empty;
  logic          bo_flag, pr_flag;
  logic [1:0]    bat;
  logic [NF-1:0] stamp_wr;
  logic [W-1:0]  rd_mux;

  sel_sync #(.N(3), .EDGE(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .raw_i({cmp_swo_i, cmp_vok_i, cmp_vlow_i}),
    .out_o(edges)
  );

  sel_sync #(.N(2), .EDGE(1'b0)) u_lvl (
    .clk(clk), .rst_n(rst_n),
    .raw_i({cmp_b75_i, cmp_b85_i}),
    .out_o(levels)
  );

  assign ev_vlow_rise = edges[0];
  assign ev_vok_rise  = edges[1];
  assign ev_swo_rise  = edges[2];
  assign rd_status    = reg_rd_i && (reg_addr_i == A_STATUS);

  sel_status u_status (
    .clk(clk), .rst_n(rst_n),
    .vlow_rise_i(ev_vlow_rise), .vok_rise_i(ev_vok_rise),
    .lo85_i(levels[0]), .lo75_i(levels[1]),
    .rd_clear_i(rd_status),
    .bo_o(bo_flag), .pr_o(pr_flag), .bat_o(bat)
  );

  for (genvar i = 0; i < NF; i++) begin : g_wdec
    assign stamp_wr[i] = reg_wr_i && (reg_addr_i == ADDR_W'(STAMP_BASE + i));
  end

  sel_stamp #(.NF(NF), .W(W)) u_stamp (
    .clk(clk), .rst_n(rst_n),
    .capture_i(ev_swo_rise), .now_i(now_i),
    .wr_i(stamp_wr), .wdata_i(reg_wdata_i),
    .stamp_o(stamp_o), .empty_o(stamp_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 trip_sel_o <= '0;
    else if (reg_wr_i && reg_addr_i == A_TRIP)  trip_sel_o <= reg_wdata_i[TRIP_W-1:0];
  end

  assign status_o     = pack_status(bo_flag, pr_flag, bat);
  assign brownout_n_o = ~bo_flag;

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == A_STATUS)    rd_mux = W'(status_o);
    else if (reg_addr_i == A_TRIP) rd_mux = W'(trip_sel_o);
    for (int i = 0; i < NF; i++)
      if (reg_addr_i == ADDR_W'(STAMP_BASE + i)) rd_mux = stamp_o[i*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/sel_checker.sv
module sel_checker #(
  parameter int NF = 6,
  parameter int W  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_vlow_rise,
  input logic          ev_vok_rise,
  input logic          ev_swo_rise,
  input logic          rd_status,
  input logic          stamp_empty,
  input logic [NF-1:0] stamp_wr,
  input logic [NF*W-1:0] now_i,
  input logic [NF*W-1:0] stamp_o,
  input logic [3:0]    status_o,
  input logic          brownout_n_o
);
  AST_BO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vlow_rise |=> status_o[0]); // R2
  AST_PIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brownout_n_o) |-> $past(ev_vlow_rise)); // R2
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !ev_vlow_rise) |=> !status_o[0]); // R3
  AST_PR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vok_rise |=> status_o[1]); // R4
  AST_BAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3] |-> status_o[2]); // R5
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_swo_rise && stamp_empty) |=> (stamp_o == $past(now_i))); // R6
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stamp_empty && stamp_wr == '0) |=> $stable(stamp_o)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && ev_vlow_rise) |=> status_o[0]); // R10
endmodule

bind supply_event_log sel_checker #(.NF(NF), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_vlow_rise(ev_vlow_rise), .ev_vok_rise(ev_vok_rise),
  .ev_swo_rise(ev_swo_rise), .rd_status(rd_status),
  .stamp_empty(stamp_empty), .stamp_wr(stamp_wr),
  .now_i(now_i), .stamp_o(stamp_o),
  .status_o(status_o), .brownout_n_o(brownout_n_o)
);

// File: tb/tb_supply_event_log.sv
`timescale 1ns/1ps
module tb_supply_event_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vlow = 0, vok = 0, b85 = 0, b75 = 0, swo = 0;
  logic [47:0] now = '0;
  logic [2:0]  addr = '0;
  logic        wr = 0, rd = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  status;
  logic        bo_n;
  logic [2:0]  trip;
  logic [47:0] stamp;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #2 clk = ~clk;

  supply_event_log dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_vlow_i(vlow), .cmp_vok_i(vok), .cmp_b85_i(b85), .cmp_b75_i(b75),
    .cmp_swo_i(swo), .now_i(now),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .status_o(status), .brownout_n_o(bo_n),
    .trip_sel_o(trip), .stamp_o(stamp)
  );

  // Monitor: a read issued in one cycle is due on reg_rdata_o after the next edge
  always @(posedge clk) pend <= rd && rst_n;
  always @(negedge clk) begin
    if (pend) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL monitor: read data %02h with no expected item", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          miscompares++;
          $display("FAIL %s: read data %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", t, act, exp);
    end
  endtask

  // Driver: called at a falling edge, pushes the expected read data
  task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string t);
    addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] t1, t2;
    t1 = {8'h24, 8'h06, 8'h15, 8'h13, 8'h45, 8'h30};
    t2 = {8'h25, 8'h01, 8'h02, 8'h07, 8'h08, 8'h09};
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 64'(status), 0);
    chk("R1 brownout_n", 64'(bo_n), 1);
    chk("R1 stamp", 64'(stamp), 0);
    chk("R1 trip", 64'(trip), 0);
    chk("R1 rdata", 64'(rdata), 0);

    // R9 trip field
    wr_reg(3'd1, 8'h05);
    chk("R9 trip", 64'(trip), 5);
    rd_reg(3'd1, 8'h05, "R9 trip read");
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, 8'h07, "R9 upper bits zero");

    // R2 brown-out flag and pin
    vlow = 1'b1;
    waitn(2);
    chk("R2 not yet", 64'(bo_n), 1);
    waitn(1);
    chk("R2 pin low", 64'(bo_n), 0);
    chk("R2 flag", 64'(status[0]), 1);

    // R3 read clears, R11 held level does not re-set
    rd_reg(3'd0, 8'h01, "R3 status read");
    chk("R3 cleared", 64'(status[0]), 0);
    chk("R3 pin released", 64'(bo_n), 1);
    waitn(4);
    rd_reg(3'd0, 8'h00, "R11 no re-set while held");

    // R4 supply restored
    vlow = 1'b0; vok = 1'b1;
    waitn(3);
    chk("R4 restored", 64'(status), 4'b0010);
    rd_reg(3'd0, 8'h02, "R4 read");
    chk("R4 cleared", 64'(status[1]), 0);
    vok = 1'b0;

    // R5 battery levels
    b85 = 1'b1;
    waitn(2);
    chk("R5 85 only", 64'(status), 4'b0100);
    rd_reg(3'd0, 8'h04, "R5 read");
    chk("R5 not cleared by read", 64'(status), 4'b0100);
    b75 = 1'b1;
    waitn(2);
    chk("R5 both", 64'(status), 4'b1100);
    b85 = 1'b0;
    waitn(2);
    chk("R5 75 implies 85", 64'(status), 4'b1100);
    b75 = 1'b0;
    waitn(2);
    chk("R5 released", 64'(status), 0);

    // R10 read in the cycle of a new brown-out edge: set wins
    vlow = 1'b1;
    waitn(2);
    rd_reg(3'd0, 8'h00, "R10 read before set");
    chk("R10 set wins", 64'(status[0]), 1);
    rd_reg(3'd0, 8'h01, "R10 flag still set");
    chk("R10 later read clears", 64'(status[0]), 0);
    vlow = 1'b0;

    // R6 capture
    now = t1;
    swo = 1'b1;
    waitn(2);
    chk("R6 not yet", 64'(stamp), 0);
    waitn(1);
    chk("R6 captured", 64'(stamp), 64'(t1));
    for (int i = 0; i < 6; i++) rd_reg(3'(2 + i), t1[i*8 +: 8], "R6 byte read");

    // R7 later switchover ignored
    now = t2;
    swo = 1'b0;
    waitn(3);
    swo = 1'b1;
    waitn(4);
    chk("R7 kept first", 64'(stamp), 64'(t1));

    // R8 clear rules
    wr_reg(3'd2, 8'h55);
    chk("R8 nonzero ignored", 64'(stamp), 64'(t1));
    for (int i = 0; i < 5; i++) wr_reg(3'(2 + i), 8'h00);
    chk("R8 per-byte clear", 64'(stamp), {8'h24, 40'h0});
    swo = 1'b0; waitn(3); swo = 1'b1; waitn(4);
    chk("R8 not rearmed", 64'(stamp), {8'h24, 40'h0});
    wr_reg(3'd7, 8'h00);
    chk("R8 all clear", 64'(stamp), 0);
    swo = 1'b0; waitn(3); swo = 1'b1; waitn(3);
    chk("R8 rearmed capture", 64'(stamp), 64'(t2));
    rd_reg(3'd7, 8'h25, "R8 year read");

    waitn(3);
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL monitor: %0d reads never answered", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule